// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock for an I2C controller from a fast reference clock. Four count registers hold a high count and a low count for standard speed and for fast speed. A speed-select input picks the pair, and the chosen pair is captured when a transfer begins. The block drives SCL low through an open-drain enable and counts each low phase from the cycle in which it pulls the line. When it releases the line, it waits until the synchronised SCL input is really high before it counts the high phase, so a target that stretches the clock extends the high phase instead of shortening it.

A bit engine asks for a START, then receives a strobe each time SCL falls. It posts a STOP request during a low phase, and the block answers with a strobe once the STOP setup time has elapsed. Every phase adds fixed cycles on top of the programmed count: one cycle for the low phase, eight for the high phase and three for the START hold. Programmed counts below six are raised to six. The count registers accept writes only while the block is disabled.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset the SCL drive is released and `start_done`, `bit_tick`, `stop_done` and `stretching` are all low.
- R2: A `start_req` seen in idle while enabled makes `scl_drive_low` and a one-cycle `start_done` rise together exactly H+3 cycles after the capturing edge, where H is the effective high count.
- R3: Each low phase lasts exactly L+1 reference cycles, where L is the effective low count.
- R4: When SCL rises as soon as it is released, the released time before the next drive-low is exactly H+8 cycles, and each such drive-low comes with a one-cycle `bit_tick`.
- R5: The high count starts only once SCL is sampled high. The next drive-low comes H+7 cycles after the first clock edge that samples `scl_in` high. `stretching` is high while the line is still low three or more cycles after release.
- R6: A `stop_req` pulse during a transfer turns the next high phase into a STOP phase. SCL stays released, `stop_done` pulses H+8 cycles after release, and the block returns to idle.
- R7: `fast_mode`, sampled with `start_req`, selects the pair. `cfg_sel` encodes 0 standard high, 1 standard low, 2 fast high, 3 fast low.
- R8: Count-register writes while `enable` is high are ignored.
- R9: Programmed counts below 6 act as 6.
- R10: Deasserting `enable` releases SCL in the next cycle, returns the block to idle and drops any pending STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; also the lock on the count registers |
| fast_mode | input | 1 | Selects the fast pair (1) or the standard pair (0) |
| cfg_we | input | 1 | Count register write strobe |
| cfg_sel | input | 2 | Count register select |
| cfg_wdata | input | CNT_W | Count register write data |
| start_req | input | 1 | Request a START from idle |
| stop_req | input | 1 | Request a STOP after the current low phase |
| scl_in | input | 1 | Sampled SCL bus level |
| scl_drive_low | output | 1 | Open-drain pull-down enable for SCL |
| start_done | output | 1 | One-cycle strobe: START hold elapsed, SCL falls |
| bit_tick | output | 1 | One-cycle strobe: bit clock complete, SCL falls |
| stop_done | output | 1 | One-cycle strobe: STOP setup elapsed |
| stretching | output | 1 | A target is holding SCL low past the rise latency |

## Verification
The hardest case to reach is a target that holds SCL low after release. The line has to stay low across the block's own release and then rise on a chosen cycle relative to the synchroniser. The bench holds the line down from inside a low phase and lets it go a swept number of cycles after release. This covers releases both before and after the three-cycle rise latency. It checks the flag and the H+8 count from the release cycle. Full sweeps of both counts across the clamp boundary, in both speed modes, cover the arithmetic of every phase.

// File: rtl/i2c_scl_timer_pkg.sv
`timescale 1ns/1ps
package i2c_scl_timer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_LOW   = 3'd2,
    PH_WAIT  = 3'd3,
    PH_HIGH  = 3'd4
  } phase_e;

  // register select encoding, decoded by the count register bank
  localparam logic [1:0] SEL_STD_HI  = 2'd0;
  localparam logic [1:0] SEL_STD_LO  = 2'd1;
  localparam logic [1:0] SEL_FAST_HI = 2'd2;
  localparam logic [1:0] SEL_FAST_LO = 2'd3;

  // fixed overheads on top of the programmed counts
  localparam int unsigned LOW_EXTRA   = 1;
  localparam int unsigned HIGH_EXTRA  = 8;
  localparam int unsigned START_EXTRA = 3;
  localparam int unsigned SYNC_STAGES = 2;
  // cycles from release until the phase machine can see a high line
  localparam int unsigned RISE_LAT    = SYNC_STAGES + 1;

endpackage

// File: rtl/i2c_scl_rst_sync.sv
`timescale 1ns/1ps
module i2c_scl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_scl_line_sync.sv
`timescale 1ns/1ps
module i2c_scl_line_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], line_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{IDLE_LV}};
    else        sh_q <= sh_d;
  end

  assign line_sync = sh_q[STAGES-1];

endmodule

// File: rtl/i2c_scl_cnt_regs.sv
`timescale 1ns/1ps
module i2c_scl_cnt_regs
  import i2c_scl_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned MIN_CNT     = 6,
  parameter int unsigned RST_STD_HI  = 400,
  parameter int unsigned RST_STD_LO  = 470,
  parameter int unsigned RST_FAST_HI = 60,
  parameter int unsigned RST_FAST_LO = 130
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fast_mode,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] hi_cnt,
  output logic [CNT_W-1:0] lo_cnt
);

  localparam int unsigned     NREG  = 4;
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);

  logic [CNT_W-1:0] cnt_q [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_cnt
      localparam logic [CNT_W-1:0] RV =
        (g == 0) ? CNT_W'(RST_STD_HI)  :
        (g == 1) ? CNT_W'(RST_STD_LO)  :
        (g == 2) ? CNT_W'(RST_FAST_HI) : CNT_W'(RST_FAST_LO);
      logic wr_en;

      always_comb wr_en = we && !enable && (sel == 2'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q[g] <= RV;
        else if (wr_en) cnt_q[g] <= wdata;
      end

      // R8
      cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(cnt_q[g]));
    end
  endgenerate

  logic [CNT_W-1:0] raw_hi, raw_lo;

  always_comb begin
    raw_hi = fast_mode ? cnt_q[SEL_FAST_HI] : cnt_q[SEL_STD_HI];
    raw_lo = fast_mode ? cnt_q[SEL_FAST_LO] : cnt_q[SEL_STD_LO];
    hi_cnt = (raw_hi < FLOOR) ? FLOOR : raw_hi;
    lo_cnt = (raw_lo < FLOOR) ? FLOOR : raw_lo;
  end

  // R9
  clamp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt >= FLOOR) && (lo_cnt >= FLOOR));

endmodule

// File: rtl/i2c_scl_phase_fsm.sv
`timescale 1ns/1ps
module i2c_scl_phase_fsm
  import i2c_scl_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             line_hi,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  output logic             scl_low,
  output logic             start_done,
  output logic             bit_tick,
  output logic             stop_done,
  output logic             stretching
);

  localparam int unsigned CW     = CNT_W + 1;
  localparam int unsigned WAIT_W = $clog2(RISE_LAT + 1);
  localparam logic [WAIT_W-1:0] WAIT_SAT = WAIT_W'(RISE_LAT);

  phase_e            phase_q, phase_d;
  logic [CW-1:0]     cnt_q, cnt_d, cnt_inc;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [CNT_W-1:0]  lat_h_q, lat_h_d, lat_l_q, lat_l_d;
  logic              stop_pend_q, stop_pend_d;
  logic              stop_ph_q, stop_ph_d;
  logic              scl_low_q, scl_low_d;
  logic              start_done_q, start_done_d;
  logic              bit_tick_q, bit_tick_d;
  logic              stop_done_q, stop_done_d;
  logic [CW-1:0]     start_tgt, low_tgt, high_tgt;

  always_comb begin
    start_tgt = CW'(lat_h_q) + CW'(START_EXTRA - 1);
    low_tgt   = CW'(lat_l_q) + CW'(LOW_EXTRA - 1);
    high_tgt  = CW'(lat_h_q) + CW'(HIGH_EXTRA - RISE_LAT - 1);
    cnt_inc   = cnt_q + 1'b1;
  end

  always_comb begin
    phase_d      = phase_q;
    cnt_d        = cnt_q;
    wait_d       = wait_q;
    lat_h_d      = lat_h_q;
    lat_l_d      = lat_l_q;
    stop_pend_d  = stop_pend_q;
    stop_ph_d    = stop_ph_q;
    scl_low_d    = scl_low_q;
    start_done_d = 1'b0;
    bit_tick_d   = 1'b0;
    stop_done_d  = 1'b0;
    if (!enable) begin
      phase_d     = PH_IDLE;
      cnt_d       = '0;
      wait_d      = '0;
      stop_pend_d = 1'b0;
      stop_ph_d   = 1'b0;
      scl_low_d   = 1'b0;
    end else begin
      if ((phase_q != PH_IDLE) && stop_req) stop_pend_d = 1'b1;
      unique case (phase_q)
        PH_IDLE: begin
          stop_pend_d = 1'b0;
          if (start_req) begin
            phase_d = PH_START;
            cnt_d   = '0;
            lat_h_d = hi_cnt;
            lat_l_d = lo_cnt;
          end
        end
        PH_START: begin
          if (cnt_q >= start_tgt) begin
            phase_d      = PH_LOW;
            cnt_d        = '0;
            scl_low_d    = 1'b1;
            start_done_d = 1'b1;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        PH_LOW: begin
          if (cnt_q >= low_tgt) begin
            phase_d     = PH_WAIT;
            wait_d      = '0;
            scl_low_d   = 1'b0;
            stop_ph_d   = stop_pend_q | stop_req;
            stop_pend_d = 1'b0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        PH_WAIT: begin
          if (line_hi) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
          end else if (wait_q != WAIT_SAT) begin
            wait_d = wait_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q >= high_tgt) begin
            if (stop_ph_q) begin
              phase_d     = PH_IDLE;
              stop_ph_d   = 1'b0;
              stop_pend_d = 1'b0;
              stop_done_d = 1'b1;
            end else begin
              phase_d    = PH_LOW;
              cnt_d      = '0;
              scl_low_d  = 1'b1;
              bit_tick_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_inc;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      cnt_q        <= '0;
      wait_q       <= '0;
      lat_h_q      <= '0;
      lat_l_q      <= '0;
      stop_pend_q  <= 1'b0;
      stop_ph_q    <= 1'b0;
      scl_low_q    <= 1'b0;
      start_done_q <= 1'b0;
      bit_tick_q   <= 1'b0;
      stop_done_q  <= 1'b0;
    end else begin
      phase_q      <= phase_d;
      cnt_q        <= cnt_d;
      wait_q       <= wait_d;
      lat_h_q      <= lat_h_d;
      lat_l_q      <= lat_l_d;
      stop_pend_q  <= stop_pend_d;
      stop_ph_q    <= stop_ph_d;
      scl_low_q    <= scl_low_d;
      start_done_q <= start_done_d;
      bit_tick_q   <= bit_tick_d;
      stop_done_q  <= stop_done_d;
    end
  end

  assign scl_low    = scl_low_q;
  assign start_done = start_done_q;
  assign bit_tick   = bit_tick_q;
  assign stop_done  = stop_done_q;
  assign stretching = (phase_q == PH_WAIT) && (wait_q == WAIT_SAT);

  // R10
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_low_q);

  // R4
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_done_q, bit_tick_q, stop_done_q}));

  // R2
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_low_q) |-> (start_done_q || bit_tick_q));

  // R5
  stretch_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stretching |-> !scl_low_q);

  // R3
  low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (cnt_q <= low_tgt));

  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done_q |-> ((phase_q == PH_IDLE) && !scl_low_q));

endmodule

// File: rtl/i2c_scl_timer.sv
`timescale 1ns/1ps
module i2c_scl_timer
  import i2c_scl_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned MIN_CNT     = 6,
  parameter int unsigned RST_STD_HI  = 400,
  parameter int unsigned RST_STD_LO  = 470,
  parameter int unsigned RST_FAST_HI = 60,
  parameter int unsigned RST_FAST_LO = 130
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fast_mode,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             start_done,
  output logic             bit_tick,
  output logic             stop_done,
  output logic             stretching
);

  logic             rst_n_i;
  logic             line_hi;
  logic [CNT_W-1:0] hi_cnt, lo_cnt;

  i2c_scl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  i2c_scl_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .line_in   (scl_in),
    .line_sync (line_hi)
  );

  i2c_scl_cnt_regs #(
    .CNT_W(CNT_W), .MIN_CNT(MIN_CNT),
    .RST_STD_HI(RST_STD_HI), .RST_STD_LO(RST_STD_LO),
    .RST_FAST_HI(RST_FAST_HI), .RST_FAST_LO(RST_FAST_LO)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .enable    (enable),
    .fast_mode (fast_mode),
    .we        (cfg_we),
    .sel       (cfg_sel),
    .wdata     (cfg_wdata),
    .hi_cnt    (hi_cnt),
    .lo_cnt    (lo_cnt)
  );

  i2c_scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .enable     (enable),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .line_hi    (line_hi),
    .hi_cnt     (hi_cnt),
    .lo_cnt     (lo_cnt),
    .scl_low    (scl_drive_low),
    .start_done (start_done),
    .bit_tick   (bit_tick),
    .stop_done  (stop_done),
    .stretching (stretching)
  );

endmodule

// File: tb/i2c_scl_timer_tb.sv
`timescale 1ns/1ps
module i2c_scl_timer_tb;

  localparam int CW  = 8;
  localparam int MIN = 6;
  localparam int WD_CYCLES = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, fast_mode = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic start_req = 1'b0, stop_req = 1'b0, hold = 1'b0;
  logic scl_in;
  logic scl_drive_low, start_done, bit_tick, stop_done, stretching;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;
  assign scl_in = !(scl_drive_low || hold);

  i2c_scl_timer #(.CNT_W(CW), .MIN_CNT(MIN),
    .RST_STD_HI(10), .RST_STD_LO(10), .RST_FAST_HI(10), .RST_FAST_LO(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .start_req(start_req), .stop_req(stop_req), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .start_done(start_done), .bit_tick(bit_tick),
    .stop_done(stop_done), .stretching(stretching));

  function automatic int eff(input int v);
    return (v < MIN) ? MIN : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = CW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int sh, input int sl, input int fh, input int fl, input bit fm);
    @(negedge clk); enable = 1'b0;
    wr(0, sh); wr(1, sl); wr(2, fh); wr(3, fl);
    fast_mode = fm;
    @(negedge clk); enable = 1'b1;
  endtask

  task automatic wait_level(input bit lvl, output int n);
    n = 0;
    while (scl_drive_low !== lvl && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic do_start(input int h, input string req);
    int n;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    wait_level(1'b1, n);
    chk(n == h + 3 && start_done === 1'b1, req, n, h + 3);
  endtask

  task automatic do_bit(input int h, input int l, input string req);
    int n;
    wait_level(1'b0, n);
    chk(n == l + 1, "R3 low phase", n, l + 1);
    wait_level(1'b1, n);
    chk(n == h + 8 && bit_tick === 1'b1, req, n, h + 8);
  endtask

  task automatic do_stop(input int h, input int l);
    int n;
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    wait_level(1'b0, n);
    chk(n + 2 == l + 1, "R3 low phase before stop", n + 2, l + 1);
    n = 0;
    while (stop_done !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    chk(n == h + 8 && scl_drive_low === 1'b0, "R6 stop strobe", n, h + 8);
    repeat (3) @(negedge clk);
    chk(scl_drive_low === 1'b0 && stop_done === 1'b0 && bit_tick === 1'b0,
        "R6 idle after stop", scl_drive_low, 0);
  endtask

  task automatic xfer(input int h, input int l, input string sreq);
    do_start(h, sreq);
    do_bit(h, l, "R4 high phase");
    do_bit(h, l, "R4 high phase");
    do_stop(h, l);
  endtask

  initial begin
    #(WD_CYCLES * 5.0);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(scl_drive_low === 1'b0 && start_done === 1'b0 && bit_tick === 1'b0 &&
        stop_done === 1'b0 && stretching === 1'b0, "R1 reset outputs", scl_drive_low, 0);

    // R7 / R9: sweep both counts across the clamp floor in both modes
    for (int m = 0; m < 2; m++)
      for (int hv = 0; hv < 12; hv++)
        for (int lv = 0; lv < 12; lv++) begin
          int eh, el;
          setup(hv, lv, lv + 1, hv + 2, m[0]);
          eh = m ? eff(lv + 1) : eff(hv);
          el = m ? eff(hv + 2) : eff(lv);
          xfer(eh, el, m ? "R7 fast pair start" : "R2 start hold");
        end

    // R9: zero counts act as the floor
    setup(0, 0, 0, 0, 1'b0);
    xfer(MIN, MIN, "R9 clamped start hold");

    // R8: writes while enabled are ignored
    setup(7, 9, 20, 20, 1'b0);
    wr(0, 30); wr(1, 30);
    xfer(7, 9, "R8 locked start hold");

    // R5: stretched high phases, released at varied offsets
    setup(7, 8, 7, 8, 1'b0);
    do_start(7, "R2 start before stretch");
    for (int s = 1; s < 10; s++) begin
      hold = 1'b1;
      wait_level(1'b0, n);
      chk(n == 9, "R3 low before stretch", n, 9);
      repeat (s) @(negedge clk);
      chk(stretching === (s >= 3) && scl_drive_low === 1'b0, "R5 stretch flag", stretching, s >= 3);
      hold = 1'b0;
      wait_level(1'b1, n);
      chk(n == 7 + 8 && bit_tick === 1'b1, "R5 high after stretch", n, 15);
      chk(stretching === 1'b0, "R5 flag cleared", stretching, 0);
    end
    do_stop(7, 8);

    // R10: disable mid low phase with a stop pending
    do_start(7, "R2 start before disable");
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0; enable = 1'b0;
    @(negedge clk);
    chk(scl_drive_low === 1'b0, "R10 release on disable", scl_drive_low, 0);
    enable = 1'b1;
    do_start(7, "R10 restart");
    do_bit(7, 8, "R10 no stale stop");
    do_stop(7, 8);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule